// File: doc/BRIEF.md
# Hypervisor Queue Pointer and State Register Bank

This block keeps the head and tail pointers of four hypervisor message queues, a trap base register and a hypervisor state register. Software updates them through a single indexed write port and reads them back through an indexed, combinational read port. From the stored values the block drives level interrupt lines.

Three of the queues signal "not empty" with a dedicated interrupt line: CPU mondo, device mondo and resumable error. A queue counts as not empty when its head and tail differ, and this is re-evaluated whenever either of its pointers is written. The fourth queue, for nonresumable errors, has storage only and no interrupt.

A write to the state register always stores the implementation id bit as 1. The same write decides the trap-level-zero interrupt from the tlz and hpriv fields and the trap level presented at that moment. The interrupt keeps its value until the state register is written again.

Top module: `hvq_regfile`

## Requirements
- R1: After reset every register reads zero and all four interrupt outputs are low.
- R2: Queue pointers live at write/read index 2q (head) and 2q+1 (tail), with q=0 CPU mondo, q=1 device mondo, q=2 resumable error, q=3 nonresumable error. A written value reads back unchanged.
- R3: After any write to a head or tail of queues 0 to 2, that queue's interrupt is high if its head and tail differ and low if they are equal.
- R4: Writes to either pointer of the nonresumable-error queue (index 6 or 7) leave all interrupt outputs unchanged.
- R5: The trap base register is at index 8. Bits 14:0 are stored as zero on a write and read as zero.
- R6: The state register is at index 9. A write stores bit 11 (id) as 1 whatever value is written, and every other bit as written.
- R7: A write to index 9 sets the trap-level-zero interrupt to 1 exactly when the written bit 0 (tlz) is 1, bit 2 (hpriv) is 0 and the trap level input is 0 in that cycle. Otherwise the write sets it to 0.
- R8: The trap-level-zero interrupt changes only on a write to index 9. A change of the trap level input alone does not alter it.
- R9: Writes to indices 10 to 15 change no register, and reads of those indices return zero.
- R10: Register and interrupt changes from a write appear right after the clock edge that accepts the write, not before.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | 4 | Register index to write |
| wr_data | input | 64 | Write value |
| rd_idx | input | 4 | Register index to read |
| rd_data | output | 64 | Read value for rd_idx (combinational) |
| trap_level | input | TL_W (3) | Current trap level |
| irq_cpu_mondo | output | 1 | CPU mondo queue not empty |
| irq_dev_mondo | output | 1 | Device mondo queue not empty |
| irq_res_err | output | 1 | Resumable error queue not empty |
| irq_tl_zero | output | 1 | Trap-level-zero interrupt |

## Verification
Each interrupt is a register of its own beside the pointers, so an interrupt flop that misses an update, or a compare against the old pointer value, shows up as an interrupt line that disagrees with the head and tail values read back in the very next cycle. A wrong trap-level-zero decision appears one cycle after the state write. A stale value then persists across later trap level changes, which the bench exposes by holding other writes while moving the trap level. Decode faults such as a wrong index, a missing mask or an id bit that is not forced appear on the next read sweep of all sixteen indices.

// File: rtl/hvq_pkg.sv
`timescale 1ns/1ps
package hvq_pkg;
    localparam int HV_DATA_W = 64;
    localparam int REG_IDX_W = 4;
    localparam int NUM_Q     = 4;
    localparam int NUM_IRQ_Q = 3;
    localparam int TBA_CLR_W = 15;
    localparam int HS_TLZ    = 0;
    localparam int HS_HPRIV  = 2;
    localparam int HS_ID     = 11;

    localparam logic [REG_IDX_W-1:0] IDX_TBA = REG_IDX_W'(2 * NUM_Q);
    localparam logic [REG_IDX_W-1:0] IDX_HST = REG_IDX_W'(2 * NUM_Q + 1);

    typedef logic [HV_DATA_W-1:0] word_t;

    localparam word_t TBA_MASK = ~((word_t'(1) << TBA_CLR_W) - word_t'(1));

    typedef enum logic [1:0] {
        Q_CPU_MONDO = 2'd0,
        Q_DEV_MONDO = 2'd1,
        Q_RES_ERR   = 2'd2,
        Q_NRES_ERR  = 2'd3
    } queue_e;

    typedef struct packed {
        logic                 en;
        logic [REG_IDX_W-1:0] idx;
        word_t                data;
    } wreq_t;

    function automatic logic [REG_IDX_W-1:0] ptr_idx(int q, bit tail);
        return REG_IDX_W'(2 * q + (tail ? 1 : 0));
    endfunction

    function automatic word_t hst_store(word_t v);
        return v | (word_t'(1) << HS_ID);
    endfunction
endpackage

// File: rtl/hvq_ptr_bank.sv
`timescale 1ns/1ps
module hvq_ptr_bank
    import hvq_pkg::*;
#(
    parameter int NQ = NUM_Q
) (
    input  logic             clk,
    input  logic             rst,
    input  wreq_t            wreq,
    output word_t [NQ-1:0]   head,
    output word_t [NQ-1:0]   tail
);
    for (genvar g = 0; g < NQ; g++) begin : g_q
        always_ff @(posedge clk) begin
            if (rst) begin
                head[g] <= '0;
                tail[g] <= '0;
            end else if (wreq.en) begin
                if (wreq.idx == ptr_idx(g, 1'b0)) head[g] <= wreq.data;
                if (wreq.idx == ptr_idx(g, 1'b1)) tail[g] <= wreq.data;
            end
        end
    end
endmodule

// File: rtl/hvq_irq_gen.sv
`timescale 1ns/1ps
module hvq_irq_gen
    import hvq_pkg::*;
#(
    parameter int NQ = NUM_IRQ_Q
) (
    input  logic           clk,
    input  logic           rst,
    input  wreq_t          wreq,
    input  word_t [NQ-1:0] head,
    input  word_t [NQ-1:0] tail,
    output logic  [NQ-1:0] irq
);
    for (genvar g = 0; g < NQ; g++) begin : g_irq
        logic hit_head, hit_tail;
        assign hit_head = wreq.en && (wreq.idx == ptr_idx(g, 1'b0));
        assign hit_tail = wreq.en && (wreq.idx == ptr_idx(g, 1'b1));

        // Compare against the value being written, not the stale pointer.
        always_ff @(posedge clk) begin
            if (rst)           irq[g] <= 1'b0;
            else if (hit_head) irq[g] <= (wreq.data != tail[g]);
            else if (hit_tail) irq[g] <= (head[g] != wreq.data);
        end
    end
endmodule

// File: rtl/hvq_hyp_regs.sv
`timescale 1ns/1ps
module hvq_hyp_regs
    import hvq_pkg::*;
#(
    parameter int TL_W = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  wreq_t           wreq,
    input  logic [TL_W-1:0] trap_level,
    output word_t           tba_q,
    output word_t           hst_q,
    output logic            irq_tlz
);
    logic hst_wr;
    assign hst_wr = wreq.en && (wreq.idx == IDX_HST);

    always_ff @(posedge clk) begin
        if (rst) begin
            tba_q   <= '0;
            hst_q   <= '0;
            irq_tlz <= 1'b0;
        end else begin
            if (wreq.en && (wreq.idx == IDX_TBA))
                tba_q <= wreq.data & TBA_MASK;
            if (hst_wr) begin
                hst_q   <= hst_store(wreq.data);
                irq_tlz <= wreq.data[HS_TLZ] && !wreq.data[HS_HPRIV]
                           && (trap_level == '0);
            end
        end
    end
endmodule

// File: rtl/hvq_read_mux.sv
`timescale 1ns/1ps
module hvq_read_mux
    import hvq_pkg::*;
#(
    parameter int NQ = NUM_Q
) (
    input  logic [REG_IDX_W-1:0] rd_idx,
    input  word_t [NQ-1:0]       head,
    input  word_t [NQ-1:0]       tail,
    input  word_t                tba,
    input  word_t                hst,
    output word_t                rd_data
);
    always_comb begin
        rd_data = '0;
        for (int q = 0; q < NQ; q++) begin
            if (rd_idx == ptr_idx(q, 1'b0)) rd_data = head[q];
            if (rd_idx == ptr_idx(q, 1'b1)) rd_data = tail[q];
        end
        if (rd_idx == IDX_TBA) rd_data = tba & TBA_MASK;
        if (rd_idx == IDX_HST) rd_data = hst;
    end
endmodule

// File: rtl/hvq_regfile.sv
`timescale 1ns/1ps
module hvq_regfile
    import hvq_pkg::*;
#(
    parameter int TL_W = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [REG_IDX_W-1:0] wr_idx,
    input  logic [HV_DATA_W-1:0] wr_data,
    input  logic [REG_IDX_W-1:0] rd_idx,
    output logic [HV_DATA_W-1:0] rd_data,
    input  logic [TL_W-1:0]      trap_level,
    output logic                 irq_cpu_mondo,
    output logic                 irq_dev_mondo,
    output logic                 irq_res_err,
    output logic                 irq_tl_zero
);
    wreq_t                  wreq;
    word_t [NUM_Q-1:0]      q_head;
    word_t [NUM_Q-1:0]      q_tail;
    logic  [NUM_IRQ_Q-1:0]  q_irq;
    word_t                  tba_q;
    word_t                  hst_q;

    assign wreq = {wr_en, wr_idx, wr_data};

    hvq_ptr_bank #(.NQ(NUM_Q)) ptr_i (
        .clk(clk), .rst(rst), .wreq(wreq), .head(q_head), .tail(q_tail)
    );

    hvq_irq_gen #(.NQ(NUM_IRQ_Q)) irq_i (
        .clk(clk), .rst(rst), .wreq(wreq),
        .head(q_head[NUM_IRQ_Q-1:0]), .tail(q_tail[NUM_IRQ_Q-1:0]),
        .irq(q_irq)
    );

    hvq_hyp_regs #(.TL_W(TL_W)) hyp_i (
        .clk(clk), .rst(rst), .wreq(wreq), .trap_level(trap_level),
        .tba_q(tba_q), .hst_q(hst_q), .irq_tlz(irq_tl_zero)
    );

    hvq_read_mux #(.NQ(NUM_Q)) rdm_i (
        .rd_idx(rd_idx), .head(q_head), .tail(q_tail),
        .tba(tba_q), .hst(hst_q), .rd_data(rd_data)
    );

    assign irq_cpu_mondo = q_irq[Q_CPU_MONDO];
    assign irq_dev_mondo = q_irq[Q_DEV_MONDO];
    assign irq_res_err   = q_irq[Q_RES_ERR];
endmodule

// File: rtl/hvq_regfile_chk.sv
`timescale 1ns/1ps
module hvq_regfile_chk
    import hvq_pkg::*;
#(
    parameter int TL_W = 3
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 wr_en,
    input logic [REG_IDX_W-1:0] wr_idx,
    input logic [HV_DATA_W-1:0] wr_data,
    input logic [TL_W-1:0]      trap_level,
    input word_t [NUM_Q-1:0]    q_head,
    input word_t [NUM_Q-1:0]    q_tail,
    input word_t                tba_q,
    input word_t                hst_q,
    input logic                 irq_cpu_mondo,
    input logic                 irq_dev_mondo,
    input logic                 irq_res_err,
    input logic                 irq_tl_zero
);
    logic [3:0] irqs;
    assign irqs = {irq_tl_zero, irq_res_err, irq_dev_mondo, irq_cpu_mondo};

    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (irqs == 4'b0));

    p_cpu_irq_r3: assert property (@(posedge clk) disable iff (rst)
        irq_cpu_mondo == (q_head[Q_CPU_MONDO] != q_tail[Q_CPU_MONDO]));
    p_dev_irq_r3: assert property (@(posedge clk) disable iff (rst)
        irq_dev_mondo == (q_head[Q_DEV_MONDO] != q_tail[Q_DEV_MONDO]));
    p_res_irq_r3: assert property (@(posedge clk) disable iff (rst)
        irq_res_err == (q_head[Q_RES_ERR] != q_tail[Q_RES_ERR]));

    p_nres_silent_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (wr_idx == ptr_idx(Q_NRES_ERR, 1'b0) ||
                   wr_idx == ptr_idx(Q_NRES_ERR, 1'b1))) |=> $stable(irqs));

    p_tba_low_zero_r5: assert property (@(posedge clk) disable iff (rst)
        tba_q[TBA_CLR_W-1:0] == '0);

    p_id_forced_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx == IDX_HST) |=> hst_q[HS_ID]);

    p_tlz_eval_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx == IDX_HST) |=>
            (irq_tl_zero == ($past(wr_data[HS_TLZ]) && !$past(wr_data[HS_HPRIV])
                             && ($past(trap_level) == '0))));

    p_tlz_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && wr_idx == IDX_HST) |=> $stable(irq_tl_zero));

    p_unused_idx_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx > IDX_HST) |=>
            ($stable(q_head) && $stable(q_tail) && $stable(tba_q) && $stable(hst_q)));
endmodule

bind hvq_regfile hvq_regfile_chk #(.TL_W(TL_W)) chk_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .trap_level(trap_level), .q_head(q_head), .q_tail(q_tail),
    .tba_q(tba_q), .hst_q(hst_q),
    .irq_cpu_mondo(irq_cpu_mondo), .irq_dev_mondo(irq_dev_mondo),
    .irq_res_err(irq_res_err), .irq_tl_zero(irq_tl_zero)
);

// File: tb/hvq_regfile_tb_top.sv
`timescale 1ns/1ps
module hvq_regfile_tb_top;
    localparam int TL_W = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic [63:0] wr_data = '0;
    logic [3:0]  rd_idx = '0;
    logic [63:0] rd_data;
    logic [TL_W-1:0] trap_level = '0;
    logic irq_cpu_mondo, irq_dev_mondo, irq_res_err, irq_tl_zero;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    bit cmp_on = 0;

    always #10 clk = ~clk;

    hvq_regfile #(.TL_W(TL_W)) dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_idx(rd_idx), .rd_data(rd_data), .trap_level(trap_level),
        .irq_cpu_mondo(irq_cpu_mondo), .irq_dev_mondo(irq_dev_mondo),
        .irq_res_err(irq_res_err), .irq_tl_zero(irq_tl_zero)
    );

    // Behavioural reference model
    logic [63:0] m_ptr [8];
    logic [63:0] m_tba, m_hst;
    bit          m_irq [3];
    bit          m_tlz;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 8; i++) m_ptr[i] = '0;
            m_tba = '0; m_hst = '0; m_tlz = 0;
            for (int i = 0; i < 3; i++) m_irq[i] = 0;
        end else if (wr_en) begin
            int idx;
            idx = int'(wr_idx);
            if (idx < 8) begin
                m_ptr[idx] = wr_data;
                if (idx / 2 < 3) m_irq[idx / 2] = (m_ptr[(idx / 2) * 2] != m_ptr[(idx / 2) * 2 + 1]);
            end else if (idx == 8) begin
                m_tba = wr_data & ~64'h7fff;
            end else if (idx == 9) begin
                m_hst = wr_data | 64'h800;
                m_tlz = wr_data[0] && !wr_data[2] && (trap_level == 0);
            end
        end
    end

    function automatic logic [63:0] exp_rd(int i);
        if (i < 8)  return m_ptr[i];
        if (i == 8) return m_tba;
        if (i == 9) return m_hst;
        return 64'h0;
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare interrupts against the model on every clock
    always @(negedge clk) begin
        if (cmp_on && !rst) begin
            chk("R3 cpu irq", {63'b0, irq_cpu_mondo}, {63'b0, m_irq[0]});
            chk("R3 dev irq", {63'b0, irq_dev_mondo}, {63'b0, m_irq[1]});
            chk("R3 res irq", {63'b0, irq_res_err},   {63'b0, m_irq[2]});
            chk("R7 tlz irq", {63'b0, irq_tl_zero},   {63'b0, m_tlz});
        end
    end

    task automatic wr(int idx, logic [63:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 4'(idx); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read_all(string tag);
        for (int i = 0; i < 16; i++) begin
            rd_idx = 4'(i);
            #1;
            chk(tag, rd_data, exp_rd(i));
        end
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        cmp_on = 1'b1;
        // R1 reset state
        chk("R1 irqs", {60'b0, irq_tl_zero, irq_res_err, irq_dev_mondo, irq_cpu_mondo}, 64'h0);
        read_all("R1 reads zero");

        // R10: no change before the accepting edge, change right after
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 4'd0; wr_data = 64'h5;
        #5 chk("R10 before edge", {63'b0, irq_cpu_mondo}, 64'h0);
        @(negedge clk);
        wr_en = 1'b0;
        chk("R10 after edge", {63'b0, irq_cpu_mondo}, 64'h1);

        // R2/R3 per queue
        wr(1, 64'h5);
        chk("R3 cpu equal", {63'b0, irq_cpu_mondo}, 64'h0);
        wr(3, 64'hdead_beef_0000_0001);
        chk("R3 dev differ", {63'b0, irq_dev_mondo}, 64'h1);
        wr(2, 64'hdead_beef_0000_0001);
        chk("R3 dev equal", {63'b0, irq_dev_mondo}, 64'h0);
        wr(4, 64'h40);
        chk("R3 res differ", {63'b0, irq_res_err}, 64'h1);
        read_all("R2 readback");

        // R4 nonresumable queue never interrupts
        wr(6, 64'h77);
        chk("R4 after head", {60'b0, irq_tl_zero, irq_res_err, irq_dev_mondo, irq_cpu_mondo}, 64'h4);
        wr(7, 64'h12);
        chk("R4 after tail", {60'b0, irq_tl_zero, irq_res_err, irq_dev_mondo, irq_cpu_mondo}, 64'h4);

        // R5 trap base masking
        wr(8, 64'hffff_ffff_ffff_ffff);
        rd_idx = 4'd8; #1;
        chk("R5 tba low bits", rd_data, 64'hffff_ffff_ffff_8000);

        // R6 id forced
        wr(9, 64'h0);
        rd_idx = 4'd9; #1;
        chk("R6 id bit", rd_data, 64'h800);

        // R7 combinations
        trap_level = 0; wr(9, 64'h1);
        chk("R7 tlz set", {63'b0, irq_tl_zero}, 64'h1);
        trap_level = 3; wr(9, 64'h1);
        chk("R7 nonzero tl", {63'b0, irq_tl_zero}, 64'h0);
        trap_level = 0; wr(9, 64'h5);
        chk("R7 hpriv", {63'b0, irq_tl_zero}, 64'h0);
        wr(9, 64'h1);
        // R8 hold across trap level changes and other writes
        trap_level = 5;
        repeat (4) @(negedge clk);
        chk("R8 hold tl", {63'b0, irq_tl_zero}, 64'h1);
        wr(0, 64'h9);
        chk("R8 hold other wr", {63'b0, irq_tl_zero}, 64'h1);

        // R9 unimplemented indices
        wr(12, 64'habcd);
        wr(15, 64'h1234);
        read_all("R9 ignored");

        // Random mix
        for (int n = 0; n < 400; n++) begin
            @(negedge clk);
            trap_level = TL_W'($urandom_range(0, 3));
            wr_en   = ($urandom_range(0, 3) != 0);
            wr_idx  = 4'($urandom_range(0, 15));
            wr_data = ($urandom_range(0, 1) != 0) ? 64'($urandom_range(0, 7))
                                                  : {$urandom, $urandom};
            if (n % 50 == 49) begin
                @(negedge clk);
                wr_en = 1'b0;
                read_all("R2 random sweep");
            end
        end
        @(negedge clk);
        wr_en = 1'b0;
        @(negedge clk);
        read_all("R2 final sweep");

        done = 1;
        finish_run();
    end
endmodule